// File: doc/BRIEF.md
# Monochrome Glyph Expansion Blitter

This block draws one text character into a 1280x1024 framebuffer. A dispatcher outside the block recognises the character-drawing command (command word 0xA21). It then pulses `start`. The block reads the rest of the command packet through a 32-bit word port that answers in the same cycle. From the packet it takes two corner words and two colour words. It then walks eleven bitmap words, each holding two 16-pixel rows. It emits one pixel per cycle on a framebuffer write port, choosing the foreground colour for a 1 bit and the background colour for a 0 bit.

Pixels are written either as 8-bit indices or as 24-bit grey levels, selected by `pix24`. While the block draws, it keeps a bounding box of the area it touched. When the last row is finished it pulses `done`.

The controller has the states IDLE, CORNER_A, CORNER_B, FG, BG, LOAD, EMIT and DONE:
- IDLE goes to CORNER_A on `start`.
- Each fetch state lasts one cycle, in the order CORNER_A, CORNER_B, FG, BG, then LOAD.
- LOAD captures a bitmap word and always moves on to EMIT.
- EMIT stays in place until a row ends:
  - after the first row of a word it stays in EMIT for the second row;
  - after the second row it returns to LOAD;
  - after the second row of the final word it moves to DONE.
- DONE returns to IDLE after one cycle.

Top module: `glyph_blit`

## Requirements
- R1: After reset, `busy`, `done`, `fb_we` and `dirty_vld` are all low.
- R2: The first corner is packet word 13 and the second corner is packet word 14. For each corner, x is bits 29:19 taken modulo 1280. For each corner, y is bits 12:3 of (word − 63), taken modulo 1024.
- R3: The foreground colour is packet word 16 and the background colour is packet word 29. With `pix24` high, a colour whose bits 23:16 equal 0 is written as 0x000000. A value of 7 is written as 0xC0C0C0. Any other value is written as 0xFFFFFF.
- R4: With `pix24` low, the colour's bits 7:0 are written on `fb_data[7:0]` and `fb_data[23:8]` is zero.
- R5: The packet is read in exactly this order, one word per cycle: 13, 14, 16, 29, 4 through 11, then 30 through 32. No other word is read.
- R6: Each bitmap word gives two rows: bits 15:0 first, then bits 31:16 on the next line. Bit n of a row half is drawn at column x+n, with 1 selecting foreground and 0 selecting background. Rows k = 0..21 go to line y+k.
- R7: Each row writes min(max(x2 − x, 0), 16) pixels, leftmost first, one per cycle.
- R8: A row whose line exceeds 1023 writes no pixel. No write ever leaves the 1280x1024 area.
- R9: `done` is high for exactly one cycle after the last row, and `busy` falls in the next cycle. A `start` received while `busy` is high is ignored.
- R10: `dirty_vld` clears when a command starts. After each row on a visible line, the box is updated:
  - `dirty_x1`/`dirty_x2` take the decoded x/x2;
  - `dirty_y1`/`dirty_y2` take the smallest and largest such line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a character command (ignored while busy) |
| pix24 | input | 1 | 1: 24-bit grey pixels, 0: 8-bit pixels; hold stable while busy |
| pkt_rd | output | 1 | Packet word read strobe |
| pkt_addr | output | 6 | Packet word index |
| pkt_data | input | 32 | Packet word, valid in the same cycle as the address |
| fb_we | output | 1 | Framebuffer pixel write |
| fb_x | output | 11 | Pixel column |
| fb_y | output | 10 | Pixel line |
| fb_data | output | 24 | Pixel value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| dirty_vld | output | 1 | Dirty box holds at least one row |
| dirty_x1 | output | 11 | Dirty box left column |
| dirty_x2 | output | 11 | Dirty box right bound (decoded x2) |
| dirty_y1 | output | 10 | Dirty box top line |
| dirty_y2 | output | 10 | Dirty box bottom line |

## Verification
A wrong word index shows on `pkt_addr` in the very cycle it occurs, so the bench logs every read and compares the sequence. A corrupted colour register, half select or column counter shows on `fb_data` or `fb_x` at the first pixel of the affected row. A miscounted row counter or span count changes the number of writes. It also moves `done` earlier or later by whole rows. A bad line bound or bad min/max logic leaves a wrong dirty box visible as soon as `done` rises.

// File: rtl/glyph_blit_pkg.sv
package glyph_blit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CORNER_A,
        ST_CORNER_B,
        ST_FG,
        ST_BG,
        ST_LOAD,
        ST_EMIT,
        ST_DONE
    } gb_state_e;

    // packet word indices (fixed by the command format)
    localparam int unsigned W_CORNER_A = 13;
    localparam int unsigned W_CORNER_B = 14;
    localparam int unsigned W_FG       = 16;
    localparam int unsigned W_BG       = 29;
    localparam int unsigned W_G1_FIRST = 4;
    localparam int unsigned W_G1_LAST  = 11;
    localparam int unsigned W_G2_FIRST = 30;
    localparam int unsigned W_G2_LAST  = 32;

    // pixels per glyph row half of a word
    localparam int unsigned ROW_PIX = 16;

    localparam logic [23:0] GREY_DARK  = 24'h000000;
    localparam logic [23:0] GREY_MID   = 24'hC0C0C0;
    localparam logic [23:0] GREY_LIGHT = 24'hFFFFFF;

endpackage

// File: rtl/gb_corner_decode.sv
module gb_corner_decode #(
    parameter int unsigned FB_W = 1280,
    parameter int unsigned FB_H = 1024,
    parameter int unsigned XW   = 11,
    parameter int unsigned YW   = 10
) (
    input  logic [31:0]   word,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y
);
    logic [31:0] less63;
    logic [11:0] x_raw;
    logic [11:0] x_mod;
    logic [10:0] y_raw;
    logic [10:0] y_mod;

    always_comb begin
        less63 = word - 32'd63;
        x_raw  = {1'b0, word[29:19]};
        y_raw  = {1'b0, less63[12:3]};
        x_mod  = (x_raw >= 12'(FB_W)) ? x_raw - 12'(FB_W) : x_raw;
        y_mod  = (y_raw >= 11'(FB_H)) ? y_raw - 11'(FB_H) : y_raw;
        x      = x_mod[XW-1:0];
        y      = y_mod[YW-1:0];
    end
endmodule

// File: rtl/gb_color_map.sv
module gb_color_map
    import glyph_blit_pkg::*;
(
    input  logic [31:0] color,
    input  logic        pix24,
    output logic [23:0] pixel
);
    always_comb begin
        if (!pix24)
            pixel = {16'h0000, color[7:0]};
        else if (color[23:16] == 8'd0)
            pixel = GREY_DARK;
        else if (color[23:16] == 8'd7)
            pixel = GREY_MID;
        else
            pixel = GREY_LIGHT;
    end
endmodule

// File: rtl/gb_span_count.sv
module gb_span_count #(
    parameter int unsigned XW      = 11,
    parameter int unsigned MAX_PIX = 16,
    parameter int unsigned CW      = $clog2(MAX_PIX + 1)
) (
    input  logic [XW-1:0] x_left,
    input  logic [XW-1:0] x_right,
    output logic [CW-1:0] count
);
    logic signed [XW:0] diff;

    always_comb begin
        diff = $signed({1'b0, x_right}) - $signed({1'b0, x_left});
        if (diff <= 0)
            count = '0;
        else if (diff > $signed((XW+1)'(MAX_PIX)))
            count = CW'(MAX_PIX);
        else
            count = diff[CW-1:0];
    end
endmodule

// File: rtl/glyph_blit.sv
module glyph_blit
    import glyph_blit_pkg::*;
#(
    parameter int unsigned FB_W   = 1280,
    parameter int unsigned FB_H   = 1024,
    parameter int unsigned PKT_AW = 6,
    parameter int unsigned XW     = $clog2(FB_W),
    parameter int unsigned YW     = $clog2(FB_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pix24,
    output logic              pkt_rd,
    output logic [PKT_AW-1:0] pkt_addr,
    input  logic [31:0]       pkt_data,
    output logic              fb_we,
    output logic [XW-1:0]     fb_x,
    output logic [YW-1:0]     fb_y,
    output logic [23:0]       fb_data,
    output logic              busy,
    output logic              done,
    output logic              dirty_vld,
    output logic [XW-1:0]     dirty_x1,
    output logic [XW-1:0]     dirty_x2,
    output logic [YW-1:0]     dirty_y1,
    output logic [YW-1:0]     dirty_y2
);
    localparam int unsigned CW   = $clog2(ROW_PIX + 1);
    localparam int unsigned PW   = $clog2(ROW_PIX);
    localparam int unsigned ROWS = 2 * ((W_G1_LAST - W_G1_FIRST + 1) + (W_G2_LAST - W_G2_FIRST + 1));
    localparam int unsigned SW   = $clog2(ROWS + 1);

    gb_state_e state_q, state_d;

    logic [XW-1:0]     x_q, x2_q;
    logic [YW-1:0]     y_q;
    logic [23:0]       fg_q, bg_q;
    logic [31:0]       glyph_q;
    logic [PKT_AW-1:0] widx_q;
    logic              half_q;
    logic [CW-1:0]     col_q, cnt_q;
    logic [SW-1:0]     sub_q;

    logic [XW-1:0] dec_x;
    logic [YW-1:0] dec_y;
    logic [23:0]   mapped;
    logic [CW-1:0] span;
    logic [YW:0]   line;
    logic [XW:0]   col_abs;
    logic [ROW_PIX-1:0] row_bits;
    logic          line_ok, row_end, last_word;

    gb_corner_decode #(.FB_W(FB_W), .FB_H(FB_H), .XW(XW), .YW(YW)) u_corner (
        .word(pkt_data), .x(dec_x), .y(dec_y)
    );

    gb_color_map u_color (
        .color(pkt_data), .pix24(pix24), .pixel(mapped)
    );

    gb_span_count #(.XW(XW), .MAX_PIX(ROW_PIX), .CW(CW)) u_span (
        .x_left(x_q), .x_right(dec_x), .count(span)
    );

    always_comb begin
        line      = {1'b0, y_q} + (YW+1)'(sub_q);
        col_abs   = {1'b0, x_q} + (XW+1)'(col_q);
        row_bits  = half_q ? glyph_q[31:16] : glyph_q[15:0];
        line_ok   = line < (YW+1)'(FB_H);
        row_end   = (state_q == ST_EMIT) && (({1'b0, col_q} + 1'b1) >= {1'b0, cnt_q});
        last_word = widx_q == PKT_AW'(W_G2_LAST);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_CORNER_A;
            ST_CORNER_A: state_d = ST_CORNER_B;
            ST_CORNER_B: state_d = ST_FG;
            ST_FG:       state_d = ST_BG;
            ST_BG:       state_d = ST_LOAD;
            ST_LOAD:     state_d = ST_EMIT;
            ST_EMIT:     if (row_end && half_q) state_d = last_word ? ST_DONE : ST_LOAD;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        pkt_rd   = 1'b1;
        pkt_addr = '0;
        unique case (state_q)
            ST_CORNER_A: pkt_addr = PKT_AW'(W_CORNER_A);
            ST_CORNER_B: pkt_addr = PKT_AW'(W_CORNER_B);
            ST_FG:       pkt_addr = PKT_AW'(W_FG);
            ST_BG:       pkt_addr = PKT_AW'(W_BG);
            ST_LOAD:     pkt_addr = widx_q;
            default:     pkt_rd   = 1'b0;
        endcase
        fb_we   = (state_q == ST_EMIT) && (col_q < cnt_q) && line_ok
                  && (col_abs < (XW+1)'(FB_W));
        fb_x    = col_abs[XW-1:0];
        fb_y    = line[YW-1:0];
        fb_data = row_bits[col_q[PW-1:0]] ? fg_q : bg_q;
        busy    = state_q != ST_IDLE;
        done    = state_q == ST_DONE;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0; x2_q <= '0; y_q <= '0;
            fg_q <= '0; bg_q <= '0; glyph_q <= '0;
            widx_q <= '0; half_q <= 1'b0; col_q <= '0; cnt_q <= '0; sub_q <= '0;
            dirty_vld <= 1'b0;
            dirty_x1 <= '0; dirty_x2 <= '0; dirty_y1 <= '0; dirty_y2 <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    dirty_vld <= 1'b0;
                    widx_q    <= PKT_AW'(W_G1_FIRST);
                    sub_q     <= '0;
                end
                ST_CORNER_A: begin
                    x_q <= dec_x;
                    y_q <= dec_y;
                end
                ST_CORNER_B: begin
                    x2_q  <= dec_x;
                    cnt_q <= span;
                end
                ST_FG: fg_q <= mapped;
                ST_BG: bg_q <= mapped;
                ST_LOAD: begin
                    glyph_q <= pkt_data;
                    half_q  <= 1'b0;
                    col_q   <= '0;
                end
                ST_EMIT: begin
                    if (row_end) begin
                        col_q  <= '0;
                        half_q <= ~half_q;
                        sub_q  <= sub_q + 1'b1;
                        if (line_ok) begin
                            dirty_vld <= 1'b1;
                            dirty_x1  <= x_q;
                            dirty_x2  <= x2_q;
                            if (!dirty_vld || line[YW-1:0] < dirty_y1) dirty_y1 <= line[YW-1:0];
                            if (!dirty_vld || line[YW-1:0] > dirty_y2) dirty_y2 <= line[YW-1:0];
                        end
                        if (half_q)
                            widx_q <= (widx_q == PKT_AW'(W_G1_LAST)) ? PKT_AW'(W_G2_FIRST)
                                                                      : widx_q + 1'b1;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/glyph_blit_chk.sv
module glyph_blit_chk #(
    parameter int unsigned FB_W = 1280,
    parameter int unsigned FB_H = 1024,
    parameter int unsigned XW   = 11,
    parameter int unsigned YW   = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          pix24,
    input logic          pkt_rd,
    input logic          fb_we,
    input logic [XW-1:0] fb_x,
    input logic [YW-1:0] fb_y,
    input logic [23:0]   fb_data,
    input logic          busy,
    input logic          done,
    input logic          dirty_vld,
    input logic [XW-1:0] dirty_x1
);
    AST_COLOR24_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we && pix24 |-> (fb_data == 24'h000000 || fb_data == 24'hC0C0C0 || fb_data == 24'hFFFFFF)); // R3
    AST_COLOR8_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we && !pix24 |-> fb_data[23:8] == 16'h0000); // R4
    AST_FETCH_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_rd |-> !fb_we); // R5
    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> busy); // R7
    AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> fb_x < XW'(FB_W)); // R8
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> {1'b0, fb_y} < (YW+1)'(FB_H)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R9
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy); // R9
    AST_DIRTY_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we && dirty_vld |-> fb_x >= dirty_x1); // R10
endmodule

bind glyph_blit glyph_blit_chk #(.FB_W(FB_W), .FB_H(FB_H), .XW(XW), .YW(YW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .pix24(pix24), .pkt_rd(pkt_rd),
    .fb_we(fb_we), .fb_x(fb_x), .fb_y(fb_y), .fb_data(fb_data),
    .busy(busy), .done(done), .dirty_vld(dirty_vld), .dirty_x1(dirty_x1)
);

// File: tb/glyph_blit_tb.sv
module glyph_blit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pix24 = 1'b0;
    logic        pkt_rd;
    logic [5:0]  pkt_addr;
    logic [31:0] pkt_data;
    logic        fb_we;
    logic [10:0] fb_x;
    logic [9:0]  fb_y;
    logic [23:0] fb_data;
    logic        busy, done, dirty_vld;
    logic [10:0] dirty_x1, dirty_x2;
    logic [9:0]  dirty_y1, dirty_y2;

    logic [31:0] pkt [0:63];
    assign pkt_data = pkt[pkt_addr];

    always #5 clk = ~clk;

    glyph_blit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix24(pix24),
        .pkt_rd(pkt_rd), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
        .fb_we(fb_we), .fb_x(fb_x), .fb_y(fb_y), .fb_data(fb_data),
        .busy(busy), .done(done), .dirty_vld(dirty_vld),
        .dirty_x1(dirty_x1), .dirty_x2(dirty_x2), .dirty_y1(dirty_y1), .dirty_y2(dirty_y2)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [23:0] got [int];
    int          wr_count;
    int          done_count;
    int          rd_log [$];

    always @(negedge clk) begin
        if (fb_we) begin
            got[int'(fb_y) * 2048 + int'(fb_x)] = fb_data;
            wr_count++;
        end
        if (pkt_rd) rd_log.push_back(int'(pkt_addr));
        if (done) done_count++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] map_color(input logic [31:0] c, input bit m24);
        if (!m24) return {16'h0, c[7:0]};
        if (c[23:16] == 8'd0) return 24'h000000;
        if (c[23:16] == 8'd7) return 24'hC0C0C0;
        return 24'hFFFFFF;
    endfunction

    function automatic int dec_x(input logic [31:0] w);
        return int'(w[29:19]) % 1280;
    endfunction

    function automatic int dec_y(input logic [31:0] w);
        logic [31:0] t;
        t = w - 32'd63;
        return int'(t[12:3]) % 1024;
    endfunction

    // one full command with expected values computed from the requirements
    task automatic run_cmd(input logic [31:0] ca, input logic [31:0] cb,
                           input logic [31:0] fg, input logic [31:0] bg,
                           input bit m24, input int seed, input bit restart_mid);
        int x, y, x2, cnt, k, line, exp_writes, ymax;
        int words [11];
        int exp_rd [$];
        logic [23:0] efg, ebg;
        logic [15:0] half;
        bit vis;
        for (int i = 0; i < 64; i++) pkt[i] = 32'hBAD0_0000 | 32'(i * 977);
        pkt[13] = ca; pkt[14] = cb; pkt[16] = fg; pkt[29] = bg;
        for (int i = 0; i < 11; i++) begin
            words[i] = (i < 8) ? 4 + i : 30 + (i - 8);
            pkt[words[i]] = 32'(seed) * 32'h9E3779B1 ^ 32'(i * 32'h01010101) ^ 32'(seed << i);
        end
        pix24 = m24;
        got.delete(); rd_log.delete(); wr_count = 0; done_count = 0;

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int c = 0; c < 2000 && done_count == 0; c++) begin
            if (restart_mid && c == 40) start = 1'b1;
            if (restart_mid && c == 41) start = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        check(!busy && done_count == 1, "R9 done single pulse then idle", done_count, 1);

        x = dec_x(ca); y = dec_y(ca); x2 = dec_x(cb);
        cnt = x2 - x; if (cnt < 0) cnt = 0; if (cnt > 16) cnt = 16;
        efg = map_color(fg, m24); ebg = map_color(bg, m24);

        exp_rd = '{13, 14, 16, 29};
        for (int i = 0; i < 11; i++) exp_rd.push_back(words[i]);
        begin
            bit same = rd_log.size() == exp_rd.size();
            if (same) for (int i = 0; i < rd_log.size(); i++) if (rd_log[i] != exp_rd[i]) same = 0;
            check(same, "R5 packet read order", rd_log.size(), exp_rd.size());
        end

        exp_writes = 0; ymax = -1;
        k = 0;
        for (int i = 0; i < 11; i++) begin
            for (int h = 0; h < 2; h++) begin
                line = y + k;
                vis = line < 1024;
                half = h ? pkt[words[i]][31:16] : pkt[words[i]][15:0];
                if (vis) begin
                    ymax = line;
                    for (int c = 0; c < cnt; c++) begin
                        logic [23:0] e;
                        int key;
                        e = half[c] ? efg : ebg;
                        key = line * 2048 + x + c;
                        exp_writes++;
                        if (got.exists(key))
                            check(got[key] == e, m24 ? "R6 R3 pixel 24-bit" : "R6 R4 pixel 8-bit", got[key], e);
                        else
                            check(0, "R6 pixel missing", key, e);
                    end
                end
                k++;
            end
        end
        check(wr_count == exp_writes, "R7 R8 write count", wr_count, exp_writes);
        if (ymax >= 0)
            check(dirty_vld && dirty_x1 == 11'(x) && dirty_x2 == 11'(x2)
                  && dirty_y1 == 10'(y) && dirty_y2 == 10'(ymax),
                  "R10 R2 dirty box", {dirty_x1, dirty_x2, dirty_y1, dirty_y2},
                  {11'(x), 11'(x2), 10'(y), 10'(ymax)});
    endtask

    function automatic logic [31:0] corner(input int xr, input int yf);
        return (32'(xr) << 19) | 32'(yf);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) pkt[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fb_we && !dirty_vld, "R1 reset state",
              {busy, done, fb_we, dirty_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fb_we && !dirty_vld, "R1 idle after reset",
              {busy, done, fb_we, dirty_vld}, 0);

        // R3 24-bit colour codes, typical 16-pixel cell
        run_cmd(corner(100, 200*8+63), corner(116, 200*8+63), 32'h0007_0000, 32'h0000_0000, 1, 1, 0);
        run_cmd(corner(40, 50*8+63),  corner(56, 50*8+63),  32'h0003_0000, 32'h0007_1234, 1, 2, 0);
        run_cmd(corner(40, 50*8+63),  corner(56, 50*8+63),  32'h0000_FFFF, 32'h00FF_0000, 1, 3, 0);
        // R4 8-bit
        run_cmd(corner(8, 9*8+63), corner(24, 9*8+63), 32'h1234_565A, 32'h00FF_FFA5, 0, 4, 0);
        // R7 sweep of span widths -2..18
        for (int d = -2; d <= 18; d++)
            run_cmd(corner(500, 300*8+63), corner(500 + d, 300*8+63),
                    32'h0000_00C3, 32'h0000_003C, 0, 10 + d, 0);
        // R2 x modulo 1280, y borrow from low bits
        run_cmd(corner(2000, 5), corner(2010, 0), 32'h0007_0000, 32'h0001_0000, 1, 40, 0);
        run_cmd(corner(1279, 63), corner(1279, 63), 32'h0000_0011, 32'h0000_0022, 0, 41, 0);
        run_cmd(corner(1263, 7777), corner(1279, 12), 32'h0000_0011, 32'h0000_0022, 0, 42, 0);
        // R8 sweep of bottom lines
        for (int yy = 1000; yy <= 1023; yy++)
            run_cmd(corner(200, yy*8+63), corner(213, 0), 32'h0009_0000, 32'h0007_0000, 1, yy, 0);
        // R9 start while busy ignored
        run_cmd(corner(64, 64*8+63), corner(80, 0), 32'h0000_0001, 32'h0000_0002, 0, 77, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule